// File: doc/BRIEF.md
# DSI Sync and Enable Generator

This block sits behind a DSI packet capture stage and turns its decoded packet events into the timing strobes of a parallel video bus. Each byte-clock cycle it sees three inputs: a one-cycle flag for a short packet, a flag that is held for the payload of a long packet, and the 6-bit data type of the current packet. From these it produces a frame-level vertical sync level, a line-level horizontal sync level, and a byte enable. The byte enable marks the payload bytes of the one long-packet type that the downstream pixel converter has been built for.

Vertical sync follows the frame-start and frame-end short packets. Horizontal sync follows the line-start and line-end short packets. It is also raised by either vertical event, so that a host which sends no line-start packet beside a frame event still produces a line pulse. Any other short packet, and every long packet, leaves both sync levels alone. Long packets of any type other than the configured pixel type, such as blanking or null packets, never raise the byte enable. All outputs are registered in the byte clock domain and appear one cycle after the event that caused them.

Top module: `dsi_sync_gen`

## Requirements
- R1: A short packet (short_evt high) with type 0x01 drives vsync high on the next cycle.
- R2: A short packet with type 0x11 drives vsync low on the next cycle.
- R3: A short packet with type 0x21 drives hsync high on the next cycle.
- R4: A short packet with type 0x31 drives hsync low on the next cycle.
- R5: A short packet with type 0x01 or 0x11 also drives hsync high on the next cycle.
- R6: A short packet with any type other than 0x01, 0x11, 0x21 or 0x31, and any cycle without short_evt, leaves vsync and hsync unchanged.
- R7: While short_evt is low, a long packet leaves vsync and hsync unchanged, even when its type equals a sync code.
- R8: payload_en is high in the cycle after each cycle in which long_evt is high and pkt_type equals PIX_TYPE (default 0x3E).
- R9: payload_en is low in the cycle after any cycle in which long_evt is low or pkt_type differs from PIX_TYPE. This includes a short packet that carries the PIX_TYPE code.
- R10: While rst_n is low, vsync, hsync and payload_en are all low at each clock edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| short_evt | input | 1 | One-cycle flag for a decoded short packet |
| long_evt | input | 1 | High for each payload cycle of a long packet |
| pkt_type | input | 6 | Data type of the current packet |
| vsync | output | 1 | Vertical sync level |
| hsync | output | 1 | Horizontal sync level |
| payload_en | output | 1 | Marks payload bytes of the configured pixel type |

## Verification
The hardest situation to reach is a type code arriving on the wrong kind of packet. Examples are a long packet whose type equals a sync code, and a short packet whose type equals the pixel type. A faulty qualifier would react to these, yet real traffic never produces them. The stimulus sends such packets on purpose while vsync and hsync hold known non-default levels, so that an unwanted set or clear shows up. It also sends the frame-end event while hsync is already low, to show the forced line pulse, and it asserts reset in the middle of a frame while sync events are still being driven.

// File: rtl/dsi_sync_pkg.sv
// Shared widths, packet codes and the decoded event record for the
// sync and enable generator. Assumes 6-bit DSI data type values.
package dsi_sync_pkg;
    localparam int TYPE_W = 6;
    typedef logic [TYPE_W-1:0] ptype_t;

    localparam ptype_t CODE_FRAME_BEGIN = 6'h01;
    localparam ptype_t CODE_FRAME_FINISH = 6'h11;
    localparam ptype_t CODE_LINE_BEGIN = 6'h21;
    localparam ptype_t CODE_LINE_FINISH = 6'h31;

    typedef struct packed {
        logic frame_begin;
        logic frame_finish;
        logic line_begin;
        logic line_finish;
    } sync_evt_t;

    localparam int NUM_LEVELS = 2;
    localparam int LVL_V = 0;
    localparam int LVL_H = 1;
endpackage

// File: rtl/dsi_evt_decode.sv
// Decodes a short-packet data type into sync events.
// Assumes short_evt lasts one cycle per packet; long packets are never
// decoded here, so a sync code on a long packet produces no event.
module dsi_evt_decode
    import dsi_sync_pkg::*;
(
    input  logic      short_evt,
    input  ptype_t    pkt_type,
    output sync_evt_t evt
);
    // Compare the type against each sync code, gated by the short flag.
    always_comb begin
        evt = '0;
        if (short_evt) begin
            evt.frame_begin  = (pkt_type == CODE_FRAME_BEGIN);
            evt.frame_finish = (pkt_type == CODE_FRAME_FINISH);
            evt.line_begin   = (pkt_type == CODE_LINE_BEGIN);
            evt.line_finish  = (pkt_type == CODE_LINE_FINISH);
        end
    end
endmodule

// File: rtl/dsi_level_flop.sv
// Set/clear level register. Set wins over clear when both arrive together.
// Assumes synchronous active-low reset.
module dsi_level_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold the level, move it on a set or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end
endmodule

// File: rtl/dsi_payload_gate.sv
// Registers a payload enable for long packets of one configured type.
// Assumes long_evt stays high over the payload of a long packet.
module dsi_payload_gate
    import dsi_sync_pkg::*;
#(
    parameter ptype_t PIX_TYPE = 6'h3E
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   long_evt,
    input  ptype_t pkt_type,
    output logic   payload_en
);
    logic type_hit;

    // Match the packet type against the configured pixel type.
    always_comb type_hit = (pkt_type == PIX_TYPE);

    // Register the qualified long-packet flag.
    always_ff @(posedge clk) begin
        if (!rst_n) payload_en <= 1'b0;
        else        payload_en <= long_evt & type_hit;
    end
endmodule

// File: rtl/dsi_sync_gen.sv
// Top: turns decoded DSI packet events into vsync, hsync and a payload
// enable, all registered in the byte clock domain with one cycle latency.
// Assumes the inputs come from a packet capture stage on the same clock.
module dsi_sync_gen
    import dsi_sync_pkg::*;
#(
    parameter logic [5:0] PIX_TYPE = 6'h3E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       short_evt,
    input  logic       long_evt,
    input  logic [5:0] pkt_type,
    output logic       vsync,
    output logic       hsync,
    output logic       payload_en
);
    sync_evt_t             evt;
    logic [NUM_LEVELS-1:0] lvl_set;
    logic [NUM_LEVELS-1:0] lvl_clr;
    logic [NUM_LEVELS-1:0] lvl_q;

    dsi_evt_decode u_decode (
        .short_evt (short_evt),
        .pkt_type  (pkt_type),
        .evt       (evt)
    );

    // Map events to set/clear of each level; frame events force a line pulse.
    always_comb begin
        lvl_set        = '0;
        lvl_clr        = '0;
        lvl_set[LVL_V] = evt.frame_begin;
        lvl_clr[LVL_V] = evt.frame_finish;
        lvl_set[LVL_H] = evt.line_begin | evt.frame_begin | evt.frame_finish;
        lvl_clr[LVL_H] = evt.line_finish;
    end

    for (genvar gi = 0; gi < NUM_LEVELS; gi++) begin : g_level
        dsi_level_flop u_lvl (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (lvl_set[gi]),
            .clr_i (lvl_clr[gi]),
            .q     (lvl_q[gi])
        );
    end

    assign vsync = lvl_q[LVL_V];
    assign hsync = lvl_q[LVL_H];

    dsi_payload_gate #(.PIX_TYPE(PIX_TYPE)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .long_evt   (long_evt),
        .pkt_type   (pkt_type),
        .payload_en (payload_en)
    );
endmodule

// File: rtl/dsi_sync_gen_checker.sv
// Port-level properties of dsi_sync_gen, attached by bind.
module dsi_sync_gen_checker
    import dsi_sync_pkg::*;
#(
    parameter logic [5:0] PIX_TYPE = 6'h3E
) (
    input logic       clk,
    input logic       rst_n,
    input logic       short_evt,
    input logic       long_evt,
    input logic [5:0] pkt_type,
    input logic       vsync,
    input logic       hsync,
    input logic       payload_en
);
    logic known_code;
    always_comb known_code = (pkt_type == CODE_FRAME_BEGIN) || (pkt_type == CODE_FRAME_FINISH) ||
                             (pkt_type == CODE_LINE_BEGIN)  || (pkt_type == CODE_LINE_FINISH);

    assert_vs_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (short_evt && pkt_type == CODE_FRAME_BEGIN) |=> vsync);
    assert_vs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (short_evt && pkt_type == CODE_FRAME_FINISH) |=> !vsync);
    assert_hs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (short_evt && pkt_type == CODE_LINE_BEGIN) |=> hsync);
    assert_hs_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (short_evt && pkt_type == CODE_LINE_FINISH) |=> !hsync);
    assert_hs_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (short_evt && (pkt_type == CODE_FRAME_BEGIN || pkt_type == CODE_FRAME_FINISH)) |=> hsync);
    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (short_evt && !known_code) |=> ($stable(vsync) && $stable(hsync)));
    assert_long_no_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!short_evt) |=> ($stable(vsync) && $stable(hsync)));
    assert_en_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (long_evt && pkt_type == PIX_TYPE) |=> payload_en);
    assert_en_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_evt || pkt_type != PIX_TYPE) |=> !payload_en);
endmodule

bind dsi_sync_gen dsi_sync_gen_checker #(.PIX_TYPE(PIX_TYPE)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .short_evt  (short_evt),
    .long_evt   (long_evt),
    .pkt_type   (pkt_type),
    .vsync      (vsync),
    .hsync      (hsync),
    .payload_en (payload_en)
);

// File: tb/dsi_sync_gen_test.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module dsi_sync_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       short_evt = 1'b0;
    logic       long_evt = 1'b0;
    logic [5:0] pkt_type = 6'h00;
    logic       vsync, hsync, payload_en;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic        mv = 1'b0, mh = 1'b0;
    logic [2:0]  exp_q[$];
    string       tag_q[$];
    logic        in_reset = 1'b1;

    always #2 clk = ~clk;

    dsi_sync_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .short_evt  (short_evt),
        .long_evt   (long_evt),
        .pkt_type   (pkt_type),
        .vsync      (vsync),
        .hsync      (hsync),
        .payload_en (payload_en)
    );

    // Apply one cycle of input and push the output expected after the next edge.
    task automatic drive(input logic s, input logic l, input logic [5:0] t, input string tag);
        logic be;
        @(negedge clk);
        short_evt = s; long_evt = l; pkt_type = t;
        if (s) begin
            case (t)
                6'h01: begin mv = 1'b1; mh = 1'b1; end
                6'h11: begin mv = 1'b0; mh = 1'b1; end
                6'h21: mh = 1'b1;
                6'h31: mh = 1'b0;
                default: ;
            endcase
        end
        be = l && (t == 6'h3E);
        exp_q.push_back({mv, mh, be});
        tag_q.push_back(tag);
    endtask

    // Monitor: after each edge, compare the outputs to the oldest expected item.
    always @(posedge clk) begin
        #1;
        if (in_reset) begin
            n_vec++;
            if ({vsync, hsync, payload_en} !== 3'b000) begin
                n_bad++;
                $display("FAIL R10: outputs %b expected 000 during reset", {vsync, hsync, payload_en});
            end
        end else if (exp_q.size() > 0) begin
            logic [2:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_vec++;
            if ({vsync, hsync, payload_en} !== e) begin
                n_bad++;
                $display("FAIL %s: {vsync,hsync,payload_en} %b expected %b", tg, {vsync, hsync, payload_en}, e);
            end
        end
    end

    // Drive sync events while reset is held; the model returns to its reset state.
    task automatic reset_phase();
        @(negedge clk);
        in_reset = 1'b1; rst_n = 1'b0;
        short_evt = 1'b1; long_evt = 1'b1; pkt_type = 6'h01;
        repeat (2) @(negedge clk);
        pkt_type = 6'h3E;
        repeat (2) @(negedge clk);
        short_evt = 1'b0; long_evt = 1'b0; pkt_type = 6'h00;
        rst_n = 1'b1;
        mv = 1'b0; mh = 1'b0;
        @(posedge clk); #1.5;
        in_reset = 1'b0;
    endtask

    initial begin
        reset_phase();
        drive(0, 0, 6'h00, "R6 idle");
        drive(1, 0, 6'h01, "R1 R5 frame begin");
        drive(0, 0, 6'h00, "R6 idle hold");
        drive(1, 0, 6'h31, "R4 line finish");
        drive(1, 0, 6'h08, "R6 unknown short");
        drive(1, 0, 6'h19, "R6 unknown short");
        drive(0, 1, 6'h21, "R7 long with line code");
        drive(1, 0, 6'h21, "R3 line begin");
        drive(0, 1, 6'h3E, "R8 payload");
        drive(0, 1, 6'h3E, "R8 payload");
        drive(0, 1, 6'h3E, "R8 payload");
        drive(0, 1, 6'h19, "R9 blanking long");
        drive(0, 1, 6'h09, "R9 null long");
        drive(1, 0, 6'h3E, "R9 short with pixel type");
        drive(0, 1, 6'h11, "R7 long with frame end code");
        drive(0, 1, 6'h31, "R7 long with line end code");
        drive(1, 0, 6'h31, "R4 line finish");
        drive(1, 0, 6'h11, "R2 R5 frame finish forces line");
        drive(1, 0, 6'h31, "R4 line finish");
        drive(1, 0, 6'h11, "R5 frame finish while low");
        drive(1, 0, 6'h11, "R2 frame finish again");
        drive(0, 1, 6'h01, "R7 long with frame begin code");
        drive(1, 0, 6'h01, "R1 frame begin");
        drive(0, 1, 6'h3E, "R8 payload");
        drive(1, 0, 6'h21, "R3 line begin after payload");
        drive(0, 0, 6'h3E, "R9 type without long flag");
        drive(0, 0, 6'h00, "R6 idle");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        reset_phase();
        drive(0, 0, 6'h00, "R10 state after mid-frame reset");
        drive(1, 0, 6'h21, "R3 line begin after reset");
        drive(0, 0, 6'h00, "R6 idle");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #20000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule